// File: doc/BRIEF.md
# Nine-bit UART receiver with address filtering

This block receives asynchronous serial frames and queues them for a consumer. A baud tick running at sixteen times the bit rate paces it. It checks each start bit at its midpoint and samples data bits in the middle of each bit period. In eight-bit mode a frame carries a byte. In nine-bit mode a ninth bit follows the byte and marks it as an address frame. Accepted frames go into a sixteen-entry queue, together with their ninth bit and a framing-error flag.

A consumer reads from the head of the queue. An interrupt output goes high while the fill level is at or above a threshold picked from four fixed levels. It falls again as soon as reads bring the level below that threshold.

For multi-drop buses, an automatic address filter can be switched on in nine-bit mode. When it is on, data frames are dropped until an address frame equal to the station address arrives. That address frame is stored and opens reception. Any other address frame closes reception again. A frame that arrives while the queue is full is lost and sets a sticky overrun flag.

Top module: `uart9_rx`

## Requirements
- R1: After reset the queue is empty (`fill` = 0, `empty` = 1), and `data_irq` and `overrun` are low.
- R2: In eight-bit mode a frame is a low start bit, eight data bits LSB first and a stop bit. The byte appears on `rd_data` with `rd_addr` = 0 and `fill` increased by one.
- R3: A low level seen on a baud tick starts a frame only if the line is still low eight ticks later, at mid start bit. A shorter low pulse stores nothing.
- R4: A low level at the stop-bit sample stores the byte with `rd_ferr` = 1. After that the receiver waits for the line to return high before it looks for a new start bit, and the next good frame has `rd_ferr` = 0.
- R5: `data_irq` is high when `fill` is at least the threshold chosen by `trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 14.
- R6: `data_irq` falls in the same cycle in which a read brings `fill` below the threshold. It is never high while the queue is empty.
- R7: A frame that completes while `fill` = 16 is discarded and sets `overrun`. `overrun` stays set until `ovr_clr` is pulsed.
- R8: In nine-bit mode (`nine_bit_en` = 1) the bit after the eighth data bit is stored and shown on `rd_addr`. With filtering off, every frame is stored.
- R9: With `auto_addr_en` = 1 in nine-bit mode, reception is closed after reset. An address frame (ninth bit 1) whose byte equals `station_addr` is stored and opens reception. Any other address frame is dropped and closes it. Data frames (ninth bit 0) are stored only while reception is open.
- R10: The queue is first-in first-out and holds 16 entries. `rd_en` with `empty` = 0 removes the head and shows the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| nine_bit_en | input | 1 | 1 selects nine-bit frames |
| auto_addr_en | input | 1 | 1 enables the hardware address filter (nine-bit mode) |
| station_addr | input | 8 | Address this station answers to |
| trig_sel | input | 2 | Interrupt threshold select (1, 4, 8, 14) |
| rd_en | input | 1 | Pop the head entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head entry byte |
| rd_addr | output | 1 | Head entry ninth bit |
| rd_ferr | output | 1 | Head entry framing error |
| fill | output | 5 | Number of entries queued |
| empty | output | 1 | Queue holds no entry |
| data_irq | output | 1 | Fill level at or above threshold |
| overrun | output | 1 | Sticky: a frame was lost to a full queue |

## Verification
Two states are hard to reach from the ports. One is the address filter moving between open and closed across a mixed run of address and data frames. The other is a full queue meeting one more frame. The bench drives a vector table of nine-bit frames in filter mode, each marked with whether it should land in the queue, so that opens, closes and re-opens fall in a single run. It then fills the queue with sixteen distinct bytes without reading, changing the threshold on the way. A seventeenth frame checks that overrun is set and that nothing was overwritten. Draining the queue then shows the threshold falling edge and the original order.

// File: rtl/uart9_rx.sv
module uart9_rx #(
  parameter int DEPTH = 16,
  parameter int OVS = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH),
  localparam int TW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rxd,
  input  logic          nine_bit_en,
  input  logic          auto_addr_en,
  input  logic [7:0]    station_addr,
  input  logic [1:0]    trig_sel,
  input  logic          rd_en,
  input  logic          ovr_clr,
  output logic [7:0]    rd_data,
  output logic          rd_addr,
  output logic          rd_ferr,
  output logic [CW-1:0] fill,
  output logic          empty,
  output logic          data_irq,
  output logic          overrun
);

  localparam logic [TW-1:0] MID  = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, STOP, HOLD} st_t;

  st_t           st;
  logic          rx_m, rx_s;
  logic [TW-1:0] tcnt;
  logic [3:0]    bcnt;
  logic [8:0]    shreg;
  logic          fr_done, fr_b9, fr_fe;
  logic [7:0]    fr_data;
  logic          listen;

  logic [9:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] thr;

  wire last_bit = bcnt == (nine_bit_en ? 4'd8 : 4'd7);
  wire filt     = nine_bit_en && auto_addr_en;
  wire hit      = fr_data == station_addr;
  wire accept   = !filt || (fr_b9 ? hit : listen);
  wire full     = fill == CW'(DEPTH);
  wire push     = fr_done && accept && !full;
  wire lost     = fr_done && accept && full;
  wire pop      = rd_en && !empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= IDLE;
      tcnt    <= '0;
      bcnt    <= '0;
      shreg   <= '0;
      fr_done <= 1'b0;
      fr_b9   <= 1'b0;
      fr_fe   <= 1'b0;
      fr_data <= '0;
    end else begin
      fr_done <= 1'b0;
      case (st)
        IDLE:
          if (baud_tick && !rx_s) begin
            st   <= START;
            tcnt <= '0;
          end
        START:
          if (baud_tick) begin
            if (tcnt == MID) begin
              st   <= rx_s ? IDLE : DATA;
              tcnt <= '0;
              bcnt <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
        DATA:
          if (baud_tick) begin
            if (tcnt == LAST) begin
              shreg <= {rx_s, shreg[8:1]};
              tcnt  <= '0;
              bcnt  <= bcnt + 1'b1;
              if (last_bit) st <= STOP;
            end else tcnt <= tcnt + 1'b1;
          end
        STOP:
          if (baud_tick) begin
            if (tcnt == LAST) begin
              fr_done <= 1'b1;
              fr_fe   <= !rx_s;
              fr_data <= nine_bit_en ? shreg[7:0] : shreg[8:1];
              fr_b9   <= nine_bit_en && shreg[8];
              st      <= rx_s ? IDLE : HOLD;
            end else tcnt <= tcnt + 1'b1;
          end
        HOLD:
          if (rx_s) st <= IDLE;
        default: st <= IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) listen <= 1'b0;
    else if (fr_done && filt && fr_b9) listen <= hit;

  always_ff @(posedge clk)
    if (push) mem[wp] <= {fr_fe, fr_b9, fr_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      fill    <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (lost)         overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end

  always_comb
    case (trig_sel)
      2'd0:    thr = CW'(1);
      2'd1:    thr = CW'(4);
      2'd2:    thr = CW'(8);
      default: thr = CW'(14);
    endcase

  assign {rd_ferr, rd_addr, rd_data} = mem[rp];
  assign empty    = fill == '0;
  assign data_irq = fill >= thr;

endmodule

// File: rtl/uart9_rx_chk.sv
module uart9_rx_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fill,
  input logic          empty,
  input logic          data_irq,
  input logic          overrun,
  input logic          ovr_clr,
  input logic          rd_en
);

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // R10
  pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !empty |=> fill <= $past(fill));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

  // R7
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fill) == CW'(DEPTH));

  // R6
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !data_irq);

endmodule

bind uart9_rx uart9_rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill(fill), .empty(empty),
  .data_irq(data_irq), .overrun(overrun), .ovr_clr(ovr_clr), .rd_en(rd_en)
);

// File: tb/sim_uart9_rx.sv
`timescale 1ns/1ps
module sim_uart9_rx;
  logic clk = 0, rst_n = 0, baud_tick = 0, rxd = 1;
  logic nine_bit_en = 0, auto_addr_en = 0, rd_en = 0, ovr_clr = 0;
  logic [7:0] station_addr = 8'h5A;
  logic [1:0] trig_sel = 0;
  logic [7:0] rd_data;
  logic rd_addr, rd_ferr, empty, data_irq, overrun;
  logic [4:0] fill;
  int checks = 0, fails = 0;
  logic [1:0] tdiv = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    tdiv <= tdiv + 1'b1;
    baud_tick <= (tdiv == 2'd3);
  end

  uart9_rx u0 (.*);

  // {stored, ninth bit, byte} for the address filter run (R9)
  localparam logic [9:0] VEC [10] = '{
    10'b0_0_00010001, 10'b0_1_00110011, 10'b0_0_00100010, 10'b1_1_01011010,
    10'b1_0_01000100, 10'b1_0_01010101, 10'b0_1_01100110, 10'b0_0_01110111,
    10'b1_1_01011010, 10'b1_0_10001000};

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stop_lvl);
    @(negedge clk);
    bit_time(1'b0);
    for (int i = 0; i < nb; i++) bit_time(d[i]);
    bit_time(stop_lvl);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(fill, 0, "R1 fill");
    check(empty, 1, "R1 empty");
    check(data_irq, 0, "R1 irq");
    check(overrun, 0, "R1 overrun");

    send(9'h0A5, 8, 1'b1);
    check(fill, 1, "R2 fill");
    check(rd_data, 8'hA5, "R2 data");
    check({rd_addr, rd_ferr}, 0, "R2 flags");
    check(data_irq, 1, "R5 trig 1");
    pop();
    check(data_irq, 0, "R6 irq after pop");

    @(negedge clk) rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    check(fill, 0, "R3 short pulse");

    send(9'h03C, 8, 1'b0);
    check(fill, 1, "R4 fill");
    check({rd_ferr, rd_data}, 9'h13C, "R4 ferr byte");
    pop();
    send(9'h05E, 8, 1'b1);
    check({rd_ferr, rd_data}, 9'h05E, "R4 recovery");
    pop();

    nine_bit_en = 1;
    send(9'h1C3, 9, 1'b1);
    send(9'h042, 9, 1'b1);
    check(fill, 2, "R8 fill");
    check({rd_addr, rd_data}, 9'h1C3, "R8 address frame");
    pop();
    check({rd_addr, rd_data}, 9'h042, "R8 data frame");
    pop();

    auto_addr_en = 1;
    for (int i = 0; i < 10; i++) begin
      send(VEC[i][8:0], 9, 1'b1);
      if (VEC[i][9]) begin
        check(fill, 1, "R9 stored");
        check({rd_addr, rd_data}, VEC[i][8:0], "R9 entry");
        pop();
      end else check(fill, 0, "R9 dropped");
    end

    nine_bit_en = 0;
    auto_addr_en = 0;
    trig_sel = 1;
    for (int i = 0; i < 16; i++) begin
      send({1'b0, 8'h10 + 8'(i)}, 8, 1'b1);
      if (i == 2) check(data_irq, 0, "R5 trig 4 below");
      if (i == 3) check(data_irq, 1, "R5 trig 4 reached");
      if (i == 6) begin trig_sel = 2; #1 check(data_irq, 0, "R5 trig 8 below"); end
      if (i == 7) begin check(data_irq, 1, "R5 trig 8 reached"); trig_sel = 3; end
      if (i == 12) check(data_irq, 0, "R5 trig 14 below");
      if (i == 13) check(data_irq, 1, "R5 trig 14 reached");
    end
    check(fill, 16, "R10 full");
    check(overrun, 0, "R7 no overrun yet");
    send(9'h0EE, 8, 1'b1);
    check(fill, 16, "R7 fill kept");
    check(overrun, 1, "R7 overrun set");
    pop();
    pop();
    check(data_irq, 1, "R6 at 14");
    pop();
    check(data_irq, 0, "R6 below 14");
    check(overrun, 1, "R7 sticky");
    for (int i = 3; i < 16; i++) begin
      check(rd_data, 8'h10 + 8'(i), "R10 order");
      pop();
    end
    check(empty, 1, "R7 dropped frame absent");
    @(negedge clk) ovr_clr = 1;
    @(negedge clk) ovr_clr = 0;
    check(overrun, 0, "R7 cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule